// File: doc/BRIEF.md
# Transmit Buffer Priority Arbiter

This block decides which of three transmit buffers in a CAN controller is sent next. Each buffer presents a transmit-request flag, a message identifier with an extended-format flag, and an 8-bit local priority. A mode input selects the compare key. When it is 0 the key is the identifier. When it is 1 the key is the local priority. The smallest key wins. Buffers with equal keys are resolved in favour of the lowest buffer number.

The protocol engine pulses `sel_start` just before it begins a frame. The arbiter compares the buffers as they stand in that cycle, so enables and priorities that changed since the last frame take effect. It then latches the winner. The winner index stays frozen until the engine pulses `frame_done`. Control is a two-state machine. `ST_IDLE` waits for a strobe. The transition `GRANT` (strobe seen with at least one request set) moves to `ST_HOLD`. The transition `EMPTY` (strobe with no request set) stays in `ST_IDLE`. `ST_HOLD` keeps the grant. The transition `RELEASE` (`frame_done`) returns to `ST_IDLE`.

Top module: `tba_arbiter`

## Requirements
- R1: After reset `win_valid` is 0 and the arbiter waits in `ST_IDLE`.
- R2: With `prio_mode` = 0, the enabled buffer with the smallest identifier key is granted on the strobe.
- R3: In identifier mode the key is 29 bits wide. An extended identifier (`buf_ext` bit = 1) is used as is. A standard identifier (`buf_ext` bit = 0) takes its low 11 bits and places them in key bits 28:18, with bits 17:0 set to zero.
- R4: With `prio_mode` = 1, the key is the 8-bit `buf_prio` value of each buffer, and the smallest value is granted. Identifiers have no effect in this mode.
- R5: When two or three enabled buffers share the smallest key, the lowest-numbered of them is granted.
- R6: A buffer whose `buf_req` bit is 0 is never granted. A strobe with `buf_req` = 0 leaves `win_valid` at 0.
- R7: While `win_valid` is 1 and no `frame_done` arrives, `win_idx` does not change, whatever the buffer inputs do.
- R8: `frame_done` while granted clears `win_valid` on the next cycle. The next strobe compares the inputs present at that strobe.
- R9: `win_idx` is a 2-bit binary buffer number, 0, 1 or 2. It is valid one cycle after the strobe edge.
- R10: A `sel_start` pulse while granted is ignored, and the held index is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_start | input | 1 | One-cycle strobe: compare the buffers now and latch the winner |
| frame_done | input | 1 | One-cycle strobe: the granted frame has finished |
| prio_mode | input | 1 | 0: compare identifiers, 1: compare local priorities |
| buf_req | input | 3 | Transmit request per buffer (bit n = buffer n) |
| buf_ext | input | 3 | Per-buffer identifier format, 1 = 29-bit, 0 = 11-bit |
| buf_id | input | 3x29 | Identifier per buffer |
| buf_prio | input | 3x8 | Local priority per buffer |
| win_valid | output | 1 | A buffer is granted |
| win_idx | output | 2 | Number of the granted buffer |

## Verification
The assertions assume that `frame_done` is only pulsed while a grant is held. They also assume that the buffer inputs are settled in the cycle in which `sel_start` is high, so the request snapshot they keep matches what the comparison saw. The bench changes inputs only on the falling clock edge. It raises `frame_done` only after it has seen `win_valid` high. It deliberately moves requests, identifiers and priorities during a held grant, because the design must ignore such changes.

// File: rtl/tba_pkg.sv
package tba_pkg;
    localparam int NBUF   = 3;
    localparam int ID_W   = 29;
    localparam int STD_W  = 11;
    localparam int PRIO_W = 8;
    localparam int IDX_W  = $clog2(NBUF);
    localparam int KEY_W  = (ID_W > PRIO_W) ? ID_W : PRIO_W;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } arb_state_t;
endpackage

// File: rtl/tba_keygen.sv
module tba_keygen
    import tba_pkg::*;
#(
    parameter int ID_W   = tba_pkg::ID_W,
    parameter int STD_W  = tba_pkg::STD_W,
    parameter int PRIO_W = tba_pkg::PRIO_W,
    parameter int KEY_W  = tba_pkg::KEY_W
) (
    input  logic              prio_mode,
    input  logic              ext,
    input  logic [ID_W-1:0]   id,
    input  logic [PRIO_W-1:0] prio,
    output logic [KEY_W-1:0]  key
);
    localparam int PAD_STD  = ID_W - STD_W;
    localparam int PAD_PRIO = KEY_W - PRIO_W;
    localparam int PAD_ID   = KEY_W - ID_W;

    logic [ID_W-1:0] id_key;

    // standard identifiers are left-aligned so they compare against extended ones
    always_comb begin
        if (ext) id_key = id;
        else     id_key = {id[STD_W-1:0], {PAD_STD{1'b0}}};
    end

    generate
        if (PAD_ID > 0) begin : g_id_pad
            always_comb begin
                if (prio_mode) key = {{PAD_PRIO{1'b0}}, prio};
                else           key = {{PAD_ID{1'b0}}, id_key};
            end
        end else begin : g_id_full
            always_comb begin
                if (prio_mode) key = {{PAD_PRIO{1'b0}}, prio};
                else           key = id_key;
            end
        end
    endgenerate
endmodule

// File: rtl/tba_pick.sv
module tba_pick
    import tba_pkg::*;
#(
    parameter int NBUF  = tba_pkg::NBUF,
    parameter int KEY_W = tba_pkg::KEY_W,
    parameter int IDX_W = tba_pkg::IDX_W
) (
    input  logic [NBUF-1:0]             en,
    input  logic [NBUF-1:0][KEY_W-1:0]  keys,
    output logic                        any,
    output logic [IDX_W-1:0]            idx
);
    logic             c_have [NBUF+1];
    logic [KEY_W-1:0] c_key  [NBUF+1];
    logic [IDX_W-1:0] c_idx  [NBUF+1];

    assign c_have[0] = 1'b0;
    assign c_key[0]  = '0;
    assign c_idx[0]  = '0;

    // linear chain: a later buffer only displaces on a strictly smaller key
    generate
        for (genvar i = 0; i < NBUF; i++) begin : g_stage
            logic take;
            assign take          = en[i] & (~c_have[i] | (keys[i] < c_key[i]));
            assign c_have[i+1]   = c_have[i] | en[i];
            assign c_key[i+1]    = take ? keys[i] : c_key[i];
            assign c_idx[i+1]    = take ? IDX_W'(i) : c_idx[i];
        end
    endgenerate

    assign any = c_have[NBUF];
    assign idx = c_idx[NBUF];
endmodule

// File: rtl/tba_arbiter.sv
module tba_arbiter
    import tba_pkg::*;
#(
    parameter int NBUF   = tba_pkg::NBUF,
    parameter int ID_W   = tba_pkg::ID_W,
    parameter int STD_W  = tba_pkg::STD_W,
    parameter int PRIO_W = tba_pkg::PRIO_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sel_start,
    input  logic                          frame_done,
    input  logic                          prio_mode,
    input  logic [NBUF-1:0]               buf_req,
    input  logic [NBUF-1:0]               buf_ext,
    input  logic [NBUF-1:0][ID_W-1:0]     buf_id,
    input  logic [NBUF-1:0][PRIO_W-1:0]   buf_prio,
    output logic                          win_valid,
    output logic [$clog2(NBUF)-1:0]       win_idx
);
    localparam int IDX_W = $clog2(NBUF);
    localparam int KEY_W = (ID_W > PRIO_W) ? ID_W : PRIO_W;

    logic [NBUF-1:0][KEY_W-1:0] keys;
    logic                       pick_any;
    logic [IDX_W-1:0]           pick_idx;
    arb_state_t                 state_q, state_d;

    generate
        for (genvar b = 0; b < NBUF; b++) begin : g_key
            tba_keygen #(
                .ID_W  (ID_W),
                .STD_W (STD_W),
                .PRIO_W(PRIO_W),
                .KEY_W (KEY_W)
            ) u_key (
                .prio_mode(prio_mode),
                .ext      (buf_ext[b]),
                .id       (buf_id[b]),
                .prio     (buf_prio[b]),
                .key      (keys[b])
            );
        end
    endgenerate

    tba_pick #(
        .NBUF (NBUF),
        .KEY_W(KEY_W),
        .IDX_W(IDX_W)
    ) u_pick (
        .en  (buf_req),
        .keys(keys),
        .any (pick_any),
        .idx (pick_idx)
    );

    // next-state logic: GRANT, EMPTY, RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (sel_start && pick_any) state_d = ST_HOLD;
            ST_HOLD: if (frame_done)            state_d = ST_IDLE;
            default:                            state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output register: index captured only on GRANT
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_valid <= 1'b0;
            win_idx   <= '0;
        end else begin
            win_valid <= (state_d == ST_HOLD);
            if (state_q == ST_IDLE && state_d == ST_HOLD)
                win_idx <= pick_idx;
        end
    end
endmodule

// File: rtl/tba_arbiter_chk.sv
module tba_arbiter_chk #(
    parameter int NBUF = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sel_start,
    input logic                    frame_done,
    input logic [NBUF-1:0]         buf_req,
    input logic                    win_valid,
    input logic [$clog2(NBUF)-1:0] win_idx
);
    logic [NBUF-1:0] req_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= buf_req;
    end

    p_idx_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (int'(win_idx) < NBUF));

    p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && !frame_done) |=> (win_valid && $stable(win_idx)));

    p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && frame_done) |=> !win_valid);

    p_winner_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_valid) |-> req_q[win_idx]);

    p_empty_no_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_valid && sel_start && (buf_req == '0)) |=> !win_valid);

    p_grant_needs_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_valid) |-> $past(sel_start));
endmodule

bind tba_arbiter tba_arbiter_chk #(.NBUF(NBUF)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_start (sel_start),
    .frame_done(frame_done),
    .buf_req   (buf_req),
    .win_valid (win_valid),
    .win_idx   (win_idx)
);

// File: tb/sim_tba_arbiter.sv
`timescale 1ns/1ps
module sim_tba_arbiter;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sel_start = 1'b0;
    logic              frame_done = 1'b0;
    logic              prio_mode = 1'b0;
    logic [2:0]        buf_req = '0;
    logic [2:0]        buf_ext = '0;
    logic [2:0][28:0]  buf_id = '0;
    logic [2:0][7:0]   buf_prio = '0;
    logic              win_valid;
    logic [1:0]        win_idx;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    tba_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .sel_start(sel_start), .frame_done(frame_done),
        .prio_mode(prio_mode), .buf_req(buf_req), .buf_ext(buf_ext),
        .buf_id(buf_id), .buf_prio(buf_prio),
        .win_valid(win_valid), .win_idx(win_idx)
    );

    typedef struct packed {
        logic        mode;
        logic [2:0]  req;
        logic [2:0]  ext;
        logic [28:0] id0;
        logic [28:0] id1;
        logic [28:0] id2;
        logic [7:0]  p0;
        logic [7:0]  p1;
        logic [7:0]  p2;
        logic        ev;
        logic [1:0]  ei;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VT [NV] = '{
        // R2: extended ids, smallest in buffer 1
        '{1'b0, 3'b111, 3'b111, 29'h100, 29'h050, 29'h200, 8'h00, 8'h00, 8'h00, 1'b1, 2'd1},
        // R3: standard 0x001 aligns to 0x40000, extended 0x3FFFF is smaller
        '{1'b0, 3'b011, 3'b010, 29'h001, 29'h3FFFF, 29'h0, 8'h00, 8'h00, 8'h00, 1'b1, 2'd1},
        // R3: standard 0x001 (0x40000) beats extended 0x40001
        '{1'b0, 3'b111, 3'b101, 29'h40001, 29'h001, 29'h1FFFFFFF, 8'h00, 8'h00, 8'h00, 1'b1, 2'd1},
        // R4: priority mode, ids would favour buffer 0
        '{1'b1, 3'b111, 3'b111, 29'h001, 29'h002, 29'h1000, 8'h30, 8'h10, 8'h05, 1'b1, 2'd2},
        // R5: priority tie between 1 and 2
        '{1'b1, 3'b111, 3'b111, 29'h0, 29'h0, 29'h0, 8'h07, 8'h03, 8'h03, 1'b1, 2'd1},
        // R5: identifier tie across all three
        '{1'b0, 3'b111, 3'b111, 29'h055, 29'h055, 29'h055, 8'h00, 8'h00, 8'h00, 1'b1, 2'd0},
        // R6: nothing requested
        '{1'b0, 3'b000, 3'b111, 29'h001, 29'h002, 29'h003, 8'h00, 8'h00, 8'h00, 1'b0, 2'd0},
        // R6: only buffer 2 requested, largest id
        '{1'b0, 3'b100, 3'b111, 29'h001, 29'h002, 29'h1FFFFFFF, 8'h00, 8'h00, 8'h00, 1'b1, 2'd2},
        // R6: buffer 0 best priority but disabled
        '{1'b1, 3'b010, 3'b111, 29'h0, 29'h0, 29'h0, 8'h00, 8'hF0, 8'h01, 1'b1, 2'd1},
        // R4/R5: all priorities 0xFF, ids ignored
        '{1'b1, 3'b111, 3'b111, 29'h300, 29'h200, 29'h100, 8'hFF, 8'hFF, 8'hFF, 1'b1, 2'd0}
    };

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic load(input vec_t v);
        prio_mode = v.mode;
        buf_req   = v.req;
        buf_ext   = v.ext;
        buf_id[0] = v.id0;  buf_id[1] = v.id1;  buf_id[2] = v.id2;
        buf_prio[0] = v.p0; buf_prio[1] = v.p1; buf_prio[2] = v.p2;
    endtask

    // strobe at negedge, sample 1 ns after the following posedge
    task automatic strobe();
        @(negedge clk);
        sel_start = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        sel_start = 1'b0;
    endtask

    task automatic release_grant();
        @(negedge clk);
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", {2'b0, win_valid}, 3'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1", {2'b0, win_valid}, 3'd0);

        for (int n = 0; n < NV; n++) begin
            @(negedge clk);
            load(VT[n]);
            sel_start = 1'b1;
            @(posedge clk); #1;
            check($sformatf("R9 vec%0d valid", n), {2'b0, win_valid}, {2'b0, VT[n].ev});
            if (VT[n].ev)
                check($sformatf("R2-5 vec%0d idx", n), {1'b0, win_idx}, {1'b0, VT[n].ei});
            @(negedge clk);
            sel_start = 1'b0;
            if (win_valid) begin
                frame_done = 1'b1;
                @(posedge clk); #1;
                check("R8 release", {2'b0, win_valid}, 3'd0);
                @(negedge clk);
                frame_done = 1'b0;
            end
        end

        // R7: inputs change during a held grant
        @(negedge clk);
        load(VT[0]);
        strobe();
        check("R7 grant", {win_valid, win_idx}, {1'b1, 2'd1});
        buf_req = 3'b101;
        buf_id[2] = 29'h0;
        prio_mode = 1'b1;
        buf_prio[0] = 8'h00;
        repeat (4) @(posedge clk);
        #1;
        check("R7 held", {win_valid, win_idx}, {1'b1, 2'd1});

        // R10: strobe during hold is ignored
        strobe();
        check("R10 ignored", {win_valid, win_idx}, {1'b1, 2'd1});

        // R8: release, then re-evaluate with current inputs (prio mode, buf0 prio 0)
        release_grant();
        #1;
        check("R8 cleared", {2'b0, win_valid}, 3'd0);
        strobe();
        check("R8 re-eval", {win_valid, win_idx}, {1'b1, 2'd0});
        release_grant();

        // R3: standard id 0x7FF aligns above every extended value below 0x1FFC0000
        @(negedge clk);
        prio_mode = 1'b0;
        buf_req = 3'b011;
        buf_ext = 3'b010;
        buf_id[0] = 29'h7FF;
        buf_id[1] = 29'h1FFBFFFF;
        strobe();
        check("R3 align", {win_valid, win_idx}, {1'b1, 2'd1});
        release_grant();

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule